// File: doc/BRIEF.md
# Turn and Brake Lamp Controller

This block keeps the lighting state of a small vehicle signalling unit: a hazard flasher, left and right turn indicators, the brake lamps, and an engine-off inactivity timer. It sits between an input conditioner and the lamp drivers. The conditioner supplies debounced levels and one-cycle change pulses for each switch; a separate flasher timer supplies a phase bit that is high during the lit half of a flash cycle. From these the block drives four active-low lamp outputs (front-left, front-right, rear-left, rear-right), a driver-enable that stays steady through a flash, and a sleep request.

The hazard flasher is push-on, push-off from one momentary button. Turn indicators are latched by momentary buttons and released by a cancel event. Hazard outranks turn; the brake state outranks both, but only on the rear lamps. When the engine level is low and neither hazard nor brake is active, a counter advances on each tick-enable pulse; after a parameterised number of ticks it raises the sleep request and forces every lamp dark until a brake, hazard or engine change pulse arrives.

Top module: `turn_brake_lamp_ctrl`

## Requirements
- R1: After reset, hazard, left, right and brake states are off, sleep_req is 0, every lamp output is 1 (dark), drv_en is 0, and the timeout counter holds its full reload value.
- R2: A pulse on tgl_hazard inverts the hazard state; a second pulse turns it off again.
- R3: A pulse on tgl_left alone sets the left state and clears right; tgl_right alone does the mirror; pulses on both in the same cycle leave the turn states unchanged. Left and right are never both on.
- R4: A pulse on tgl_cancel clears both turn states, and wins over a left or right pulse in the same cycle.
- R5: With hazard on, all four lamps are lit exactly while flash_lit is 1, regardless of the turn states.
- R6: With hazard off and one turn state on, the front and rear lamp on that side are lit exactly while flash_lit is 1; the lamps on the other side stay dark.
- R7: A pulse on tgl_brake loads the brake state from brake_lvl. While the brake state is on, both rear lamps are lit steadily whatever flash_lit is, and the front lamps keep their hazard or turn behaviour.
- R8: Lamp outputs are active low: 0 means lit, 1 means dark.
- R9: drv_en is 1 whenever any of hazard, left, right or brake is on and no sleep is requested, including the dark half of a flash.
- R10: The counter advances once per tick pulse only while engine_lvl is 0 and hazard and brake are both off; sleep_req rises on exactly the TIMEOUT_TICKS-th such tick after a reload, and further ticks change nothing.
- R11: A pulse on tgl_engine, tgl_hazard or tgl_brake reloads the counter and clears sleep_req in the next cycle.
- R12: While sleep_req is 1, all four lamps are dark and drv_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timeout tick enable, one cycle per timer step |
| flash_lit | input | 1 | Flasher phase, 1 during the lit half |
| engine_lvl | input | 1 | Debounced engine-on level |
| brake_lvl | input | 1 | Debounced brake switch level |
| tgl_engine | input | 1 | Engine switch change pulse |
| tgl_brake | input | 1 | Brake switch change pulse |
| tgl_hazard | input | 1 | Hazard button press pulse |
| tgl_left | input | 1 | Left button press pulse |
| tgl_right | input | 1 | Right button press pulse |
| tgl_cancel | input | 1 | Cancel event pulse |
| lamp_fl_n | output | 1 | Front-left lamp, active low |
| lamp_fr_n | output | 1 | Front-right lamp, active low |
| lamp_rl_n | output | 1 | Rear-left lamp, active low |
| lamp_rr_n | output | 1 | Rear-right lamp, active low |
| drv_en | output | 1 | Shared lamp driver enable |
| sleep_req | output | 1 | Power-down request |

## Verification
Every state bit reaches the lamp outputs combinationally, so a wrong hazard, turn or brake bit shows on the lamps in the first cycle after the pulse that set it, once flash_lit is driven to the phase where that bit matters; the bench therefore sweeps all combinations of state and phase. A wrong counter value is invisible until it ends, and shows as sleep_req rising one or more ticks early or late, or not at all, so the timeout is checked on the exact tick count, on the tick before, and with each blocking condition held.

// File: rtl/turn_brake_lamp_ctrl.sv
module turn_brake_lamp_ctrl #(
  parameter int TIMEOUT_TICKS = 9155
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic flash_lit,
  input  logic engine_lvl,
  input  logic brake_lvl,
  input  logic tgl_engine,
  input  logic tgl_brake,
  input  logic tgl_hazard,
  input  logic tgl_left,
  input  logic tgl_right,
  input  logic tgl_cancel,
  output logic lamp_fl_n,
  output logic lamp_fr_n,
  output logic lamp_rl_n,
  output logic lamp_rr_n,
  output logic drv_en,
  output logic sleep_req
);

  localparam int CW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CW-1:0] RELOAD = CW'(TIMEOUT_TICKS);

  logic hazard_q, left_q, right_q, brake_q, sleep_q;
  logic [CW-1:0] cnt_q;
  logic [3:0] lit;

  wire reload = tgl_engine | tgl_brake | tgl_hazard;
  wire run    = tick & ~engine_lvl & ~hazard_q & ~brake_q & (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hazard_q <= 1'b0;
      left_q   <= 1'b0;
      right_q  <= 1'b0;
      brake_q  <= 1'b0;
    end else begin
      hazard_q <= hazard_q ^ tgl_hazard;
      if (tgl_brake) brake_q <= brake_lvl;
      if (tgl_cancel) begin
        left_q  <= 1'b0;
        right_q <= 1'b0;
      end else if (tgl_left ^ tgl_right) begin
        left_q  <= tgl_left;
        right_q <= tgl_right;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || reload) begin
      cnt_q   <= RELOAD;
      sleep_q <= 1'b0;
    end else if (run) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) sleep_q <= 1'b1;
    end
  end

  always_comb begin
    lit = 4'b0000;
    if (hazard_q)     lit = {4{flash_lit}};
    else if (left_q)  lit = {flash_lit, 1'b0, flash_lit, 1'b0};
    else if (right_q) lit = {1'b0, flash_lit, 1'b0, flash_lit};
    if (brake_q)      lit[1:0] = 2'b11;
    if (sleep_q)      lit = 4'b0000;
  end

  assign {lamp_fl_n, lamp_fr_n, lamp_rl_n, lamp_rr_n} = ~lit;
  assign drv_en    = ~sleep_q & (hazard_q | left_q | right_q | brake_q);
  assign sleep_req = sleep_q;

  always_comb begin
    if (rst_n) a_turn_exclusive_r3: assert (!(left_q && right_q));
  end

  p_hazard_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tgl_hazard |=> hazard_q != $past(hazard_q));

  p_cancel_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tgl_cancel |=> !left_q && !right_q);

  p_brake_rear_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (brake_q && !sleep_q) |-> (!lamp_rl_n && !lamp_rr_n));

  p_drv_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((hazard_q || left_q || right_q || brake_q) && !sleep_q) |-> drv_en);

  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !reload) |=> cnt_q == '0);

  p_zero_means_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> sleep_q);

  p_reload_wakes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !sleep_req && cnt_q == RELOAD);

  p_sleep_dark_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> (lamp_fl_n && lamp_fr_n && lamp_rl_n && lamp_rr_n && !drv_en));

endmodule

// File: tb/test_turn_brake_lamp_ctrl.sv
module test_turn_brake_lamp_ctrl;
  localparam int TO = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, flash_lit = 0, engine_lvl = 1, brake_lvl = 0;
  logic tgl_engine = 0, tgl_brake = 0, tgl_hazard = 0;
  logic tgl_left = 0, tgl_right = 0, tgl_cancel = 0;
  logic lamp_fl_n, lamp_fr_n, lamp_rl_n, lamp_rr_n, drv_en, sleep_req;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  turn_brake_lamp_ctrl #(.TIMEOUT_TICKS(TO)) i_turn_brake_lamp_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .flash_lit(flash_lit),
    .engine_lvl(engine_lvl), .brake_lvl(brake_lvl),
    .tgl_engine(tgl_engine), .tgl_brake(tgl_brake), .tgl_hazard(tgl_hazard),
    .tgl_left(tgl_left), .tgl_right(tgl_right), .tgl_cancel(tgl_cancel),
    .lamp_fl_n(lamp_fl_n), .lamp_fr_n(lamp_fr_n), .lamp_rl_n(lamp_rl_n),
    .lamp_rr_n(lamp_rr_n), .drv_en(drv_en), .sleep_req(sleep_req));

  wire [5:0] outs = {lamp_fl_n, lamp_fr_n, lamp_rl_n, lamp_rr_n, drv_en, sleep_req};

  task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", tag, got, exp);
    end
  endtask

  function automatic logic [5:0] model(input bit hz, input bit l, input bit r,
                                       input bit bk, input bit fl, input bit sl);
    logic [3:0] lit;
    lit = 4'b0;
    if (hz) lit = {4{fl}};
    else if (l) lit = {fl, 1'b0, fl, 1'b0};
    else if (r) lit = {1'b0, fl, 1'b0, fl};
    if (bk) lit[1:0] = 2'b11;
    if (sl) lit = 4'b0;
    return {~lit, !sl && (hz || l || r || bk), sl};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tick = 0; flash_lit = 0; engine_lvl = 1; brake_lvl = 0;
    {tgl_engine, tgl_brake, tgl_hazard, tgl_left, tgl_right, tgl_cancel} = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic pulse(input logic [5:0] p);
    @(negedge clk);
    {tgl_engine, tgl_brake, tgl_hazard, tgl_left, tgl_right, tgl_cancel} = p;
    @(negedge clk);
    {tgl_engine, tgl_brake, tgl_hazard, tgl_left, tgl_right, tgl_cancel} = '0;
  endtask

  localparam logic [5:0] P_ENG = 6'b100000, P_BRK = 6'b010000, P_HZ = 6'b001000,
                         P_L = 6'b000100, P_R = 6'b000010, P_C = 6'b000001;

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
    end
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    do_reset();
    #1 chk("R1 reset state", outs, 6'b111100);

    // R5 R6 R7 R8 R9: sweep hazard x turn x brake x flash phase
    for (int hz = 0; hz < 2; hz++)
      for (int t = 0; t < 3; t++)
        for (int bk = 0; bk < 2; bk++)
          for (int fl = 0; fl < 2; fl++) begin
            do_reset();
            if (hz != 0) pulse(P_HZ);
            if (t == 1) pulse(P_L);
            if (t == 2) pulse(P_R);
            if (bk != 0) begin brake_lvl = 1; pulse(P_BRK); end
            flash_lit = fl[0];
            #1 chk($sformatf("R5/R6/R7/R8/R9 hz=%0d turn=%0d brk=%0d fl=%0d", hz, t, bk, fl),
                   outs, model(hz != 0, t == 1, t == 2, bk != 0, fl != 0, 1'b0));
          end

    // R2: second hazard press turns it off
    do_reset(); flash_lit = 1;
    pulse(P_HZ); #1 chk("R2 hazard on", outs, model(1,0,0,0,1,0));
    pulse(P_HZ); #1 chk("R2 hazard off", outs, model(0,0,0,0,1,0));

    // R3: left then right replaces, both together no change
    pulse(P_L); pulse(P_R); #1 chk("R3 right replaces left", outs, model(0,0,1,0,1,0));
    pulse(P_L | P_R); #1 chk("R3 both pulses ignored", outs, model(0,0,1,0,1,0));
    pulse(P_L); #1 chk("R3 left replaces right", outs, model(0,1,0,0,1,0));

    // R4: cancel, and cancel winning over a set
    pulse(P_C); #1 chk("R4 cancel clears", outs, model(0,0,0,0,1,0));
    pulse(P_R | P_C); #1 chk("R4 cancel wins over set", outs, model(0,0,0,0,1,0));

    // R7: brake release via brake_lvl=0 toggle
    brake_lvl = 1; pulse(P_BRK); flash_lit = 0;
    #1 chk("R7 brake on", outs, model(0,0,0,1,0,0));
    brake_lvl = 0; pulse(P_BRK); #1 chk("R7 brake off", outs, model(0,0,0,0,0,0));

    // R10: exact tick count, engine level blocks
    do_reset(); flash_lit = 1; pulse(P_L); engine_lvl = 1;
    ticks(3 * TO); #1 chk("R10 engine high holds", outs, model(0,1,0,0,1,0));
    pulse(P_ENG); engine_lvl = 0;
    ticks(TO - 1); #1 chk("R10 one tick early", outs, model(0,1,0,0,1,0));
    ticks(1); #1 chk("R10 expiry / R12 dark", outs, model(0,1,0,0,1,1));
    ticks(4); #1 chk("R10 no further change", outs, model(0,1,0,0,1,1));

    // R11: engine toggle wakes and reloads full count
    pulse(P_ENG); #1 chk("R11 engine toggle wakes", outs, model(0,1,0,0,1,0));
    ticks(TO - 1); #1 chk("R11 full reload", outs, model(0,1,0,0,1,0));
    ticks(1); #1 chk("R10 second expiry", outs, model(0,1,0,0,1,1));

    // R10: brake on blocks counting; R11 brake toggle wakes
    brake_lvl = 1; pulse(P_BRK); #1 chk("R11 brake wakes", outs, model(0,1,0,1,1,0));
    ticks(3 * TO); #1 chk("R10 brake holds", outs, model(0,1,0,1,1,0));
    brake_lvl = 0; pulse(P_BRK);
    ticks(TO - 1); #1 chk("R10 after brake release", outs, model(0,1,0,0,1,0));
    ticks(1); #1 chk("R10 expiry after brake", outs, model(0,1,0,0,1,1));

    // R10: hazard on blocks counting; R11 hazard toggle wakes
    pulse(P_HZ); ticks(3 * TO);
    #1 chk("R10 hazard holds / R11", outs, model(1,1,0,0,1,0));
    pulse(P_HZ); ticks(TO);
    #1 chk("R12 sleep after hazard off", outs, model(0,1,0,0,1,1));

    finish_up();
  end
endmodule